// File: doc/BRIEF.md
# Hardware-to-Software Event Port

This block carries single-cycle events from hardware state machines to software through a small memory-mapped register port. Each event channel has its own pending flag, a latched data value and a write-one acknowledge. When a strobe arrives, the channel stores its data word and raises its pending flag in the same clock edge. The flag stays raised until software writes a one to that channel's acknowledge bit, which gives a request-acknowledge handshake.

Each channel is set to one of two delivery modes. In polled mode, software scans the pending register, reads the values it finds and acknowledges them. In interrupt mode, a pending channel drives a shared interrupt request, and the port also gives a vector number for the lowest-numbered channel that is requesting. If a second strobe reaches a channel that is still pending, the new data replaces the old value and a sticky overrun flag records that an event was lost.

Register map (addresses on `bus_addr`): 0 is pending on read and acknowledge on write; 1 is delivery mode; 2 is overrun on read and write-one-to-clear; 4+i is the value of channel i, which is read-only. All other addresses read as zero. In every bit-mapped register, bit i belongs to channel i.

Top module: `evt_poll_port`

## Requirements
- R1: A strobe on channel i latches `ev_data[i*DATA_W +: DATA_W]` into the channel's value register (address 4+i) and sets pending bit i at the same clock edge.
- R2: Pending bit i stays set until a write to address 0 with data bit i equal to 1. A write bit of 0 leaves the pending bit unchanged.
- R3: If an acknowledge of channel i and a new strobe on channel i occur in the same cycle, pending bit i stays set, the value takes the new data and no overrun is recorded.
- R4: A strobe on a channel that is pending and not acknowledged in the same cycle overwrites the value, keeps pending set and sets overrun bit i (address 2). That bit stays set until a write of 1 to bit i at address 2. If a clear and a new overrun occur in the same cycle, the bit remains set.
- R5: Address 1 holds one mode bit per channel (1 = interrupt, 0 = polled), can be read and written, and resets to 0. `irq` is high exactly when at least one channel is both pending and in interrupt mode.
- R6: `irq_vec` equals VEC_BASE plus the index of the lowest-numbered channel that is pending and in interrupt mode, and equals 0 while `irq` is low.
- R7: A read (`bus_rd`) returns the addressed register on `rd_data` one cycle later and does not change any pending, overrun or value state. Unmapped addresses read as 0, and writes to value addresses are ignored.
- R8: After reset, all pending, overrun, mode and value registers read 0 and `irq` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| ev_strobe | input | NUM_EV | One-cycle event strobes, one per channel |
| ev_data | input | NUM_EV*DATA_W | Event data, channel i in slice i |
| bus_addr | input | ADDR_W | Register address |
| bus_wr | input | 1 | Write enable |
| bus_rd | input | 1 | Read enable |
| bus_wdata | input | DATA_W | Write data |
| rd_data | output | DATA_W | Read data, valid the cycle after `bus_rd` |
| irq | output | 1 | Interrupt request |
| irq_vec | output | VEC_W | Vector of the highest-priority requesting channel |

## Verification
A pending flag that is stuck or cleared at the wrong time appears at `irq` and `irq_vec` in the very next cycle for channels in interrupt mode. For polled channels, the same fault appears at the next read of address 0. A value register that is latched at the wrong edge or disturbed by a read shows a wrong word on `rd_data` one cycle after the next value read. Overrun faults surface at the next read of address 2. The reference model predicts every one of these outputs on every cycle, so any divergence is reported at the first cycle that can show it.

// File: rtl/evt_port_pkg.sv
package evt_port_pkg;
  localparam int ADR_PEND  = 0;  // read: pending, write: acknowledge
  localparam int ADR_MODE  = 1;  // delivery mode per channel
  localparam int ADR_OVR   = 2;  // overrun, write-one-to-clear
  localparam int ADR_VAL0  = 4;  // first value register

  typedef enum logic {
    DLV_POLL = 1'b0,
    DLV_IRQ  = 1'b1
  } dlv_mode_e;
endpackage

// File: rtl/evt_port_slot.sv
module evt_port_slot #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              strobe,
  input  logic [DATA_W-1:0] data,
  input  logic              ack,
  input  logic              ovr_clr,
  output logic              pend,
  output logic              ovr,
  output logic [DATA_W-1:0] value
);
  logic pend_d, ovr_d, val_en;

  always_comb begin
    pend_d = strobe | (pend & ~ack);
    ovr_d  = (strobe & pend & ~ack) | (ovr & ~ovr_clr);
    val_en = strobe;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend  <= 1'b0;
      ovr   <= 1'b0;
      value <= '0;
    end else begin
      pend <= pend_d;
      ovr  <= ovr_d;
      if (val_en) value <= data;
    end
  end

  AST_STROBE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    strobe |=> pend && value == $past(data));                         // R1
  AST_HOLD_NO_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    (pend && !ack) |=> pend);                                         // R2
  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !strobe) |=> !pend);                                      // R2
  AST_ACK_RACE: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && strobe && !ovr && !ovr_clr) |=> pend && !ovr);            // R3
  AST_OVERRUN: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe && pend && !ack) |=> ovr);                                // R4
  AST_VALUE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe |=> $stable(value));                                      // R7
endmodule

// File: rtl/evt_port_irq.sv
module evt_port_irq #(
  parameter int NUM_EV   = 4,
  parameter int VEC_W    = 8,
  parameter int VEC_BASE = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_EV-1:0] pend,
  input  logic [NUM_EV-1:0] mode,
  output logic              irq,
  output logic [VEC_W-1:0]  irq_vec
);
  localparam int IDX_W = (NUM_EV > 1) ? $clog2(NUM_EV) : 1;

  logic [NUM_EV-1:0] req;
  logic [IDX_W-1:0]  win_idx;
  logic              any_req;

  always_comb begin
    req     = pend & mode;
    any_req = 1'b0;
    win_idx = '0;
    for (int i = NUM_EV - 1; i >= 0; i--) begin
      if (req[i]) begin
        any_req = 1'b1;
        win_idx = IDX_W'(i);
      end
    end
    irq     = any_req;
    irq_vec = any_req ? VEC_W'(VEC_BASE + int'(win_idx)) : '0;
  end

  AST_IRQ_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (pend[win_idx] && mode[win_idx]));                        // R5
  AST_VEC_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !irq |-> irq_vec == '0);                                          // R6
endmodule

// File: rtl/evt_poll_port.sv
module evt_poll_port
  import evt_port_pkg::*;
#(
  parameter int NUM_EV   = 4,
  parameter int DATA_W   = 8,
  parameter int ADDR_W   = 4,
  parameter int VEC_W    = 8,
  parameter int VEC_BASE = 32
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NUM_EV-1:0]        ev_strobe,
  input  logic [NUM_EV*DATA_W-1:0] ev_data,
  input  logic [ADDR_W-1:0]        bus_addr,
  input  logic                     bus_wr,
  input  logic                     bus_rd,
  input  logic [DATA_W-1:0]        bus_wdata,
  output logic [DATA_W-1:0]        rd_data,
  output logic                     irq,
  output logic [VEC_W-1:0]         irq_vec
);
  // Reset: asynchronous assert, synchronous release.
  logic [1:0] rst_sync;
  logic       rst_q_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_q_n = rst_sync[1];

  logic [NUM_EV-1:0] pend, ovr, ack_vec, clr_vec;
  logic [NUM_EV-1:0] mode_q, mode_d;
  logic              mode_en;
  logic [DATA_W-1:0] value [NUM_EV];
  logic [DATA_W-1:0] rd_mux, rd_d;

  always_comb begin
    ack_vec = '0;
    clr_vec = '0;
    mode_en = 1'b0;
    mode_d  = mode_q;
    if (bus_wr) begin
      if (bus_addr == ADDR_W'(ADR_PEND)) ack_vec = bus_wdata[NUM_EV-1:0];
      if (bus_addr == ADDR_W'(ADR_OVR))  clr_vec = bus_wdata[NUM_EV-1:0];
      if (bus_addr == ADDR_W'(ADR_MODE)) begin
        mode_en = 1'b1;
        mode_d  = bus_wdata[NUM_EV-1:0];
      end
    end
  end

  for (genvar g = 0; g < NUM_EV; g++) begin : g_slot
    evt_port_slot #(.DATA_W(DATA_W)) u_slot (
      .clk    (clk),
      .rst_n  (rst_q_n),
      .strobe (ev_strobe[g]),
      .data   (ev_data[g*DATA_W +: DATA_W]),
      .ack    (ack_vec[g]),
      .ovr_clr(clr_vec[g]),
      .pend   (pend[g]),
      .ovr    (ovr[g]),
      .value  (value[g])
    );
  end

  always_comb begin
    rd_mux = '0;
    if (bus_addr == ADDR_W'(ADR_PEND)) rd_mux = DATA_W'(pend);
    if (bus_addr == ADDR_W'(ADR_MODE)) rd_mux = DATA_W'(mode_q);
    if (bus_addr == ADDR_W'(ADR_OVR))  rd_mux = DATA_W'(ovr);
    for (int i = 0; i < NUM_EV; i++) begin
      if (bus_addr == ADDR_W'(ADR_VAL0 + i)) rd_mux = value[i];
    end
    rd_d = bus_rd ? rd_mux : rd_data;
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      mode_q  <= '0;
      rd_data <= '0;
    end else begin
      if (mode_en) mode_q <= mode_d;
      rd_data <= rd_d;
    end
  end

  evt_port_irq #(
    .NUM_EV  (NUM_EV),
    .VEC_W   (VEC_W),
    .VEC_BASE(VEC_BASE)
  ) u_irq (
    .clk    (clk),
    .rst_n  (rst_q_n),
    .pend   (pend),
    .mode   (mode_q),
    .irq    (irq),
    .irq_vec(irq_vec)
  );

  AST_READ_QUIET: assert property (@(posedge clk) disable iff (!rst_q_n)
    (bus_rd && !bus_wr && ev_strobe == '0) |=> $stable(pend) && $stable(ovr)); // R7
  AST_MODE_HOLD: assert property (@(posedge clk) disable iff (!rst_q_n)
    !bus_wr |=> $stable(mode_q));                                     // R5
  AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_q_n)
    (ovr != '0 && !bus_wr) |=> $countones(ovr) >= $countones($past(ovr))); // R4
endmodule

// File: tb/evt_poll_port_test.sv
module evt_poll_port_test;
  localparam int N  = 4;
  localparam int DW = 8;
  localparam int AW = 4;
  localparam int VW = 8;
  localparam int VB = 32;

  logic            clk = 1'b0;
  logic            rst_n;
  logic [N-1:0]    ev_strobe;
  logic [N*DW-1:0] ev_data;
  logic [AW-1:0]   bus_addr;
  logic            bus_wr, bus_rd;
  logic [DW-1:0]   bus_wdata;
  logic [DW-1:0]   rd_data;
  logic            irq;
  logic [VW-1:0]   irq_vec;

  always #10 clk = ~clk;  // 50 MHz

  evt_poll_port #(.NUM_EV(N), .DATA_W(DW), .ADDR_W(AW), .VEC_W(VW), .VEC_BASE(VB)) uut (
    .clk(clk), .rst_n(rst_n), .ev_strobe(ev_strobe), .ev_data(ev_data),
    .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata),
    .rd_data(rd_data), .irq(irq), .irq_vec(irq_vec)
  );

  int    n_cmp  = 0;
  int    n_bad  = 0;
  string rd_tag = "";

  // behavioural reference state
  int m_pend[N];
  int m_ovr[N];
  int m_mode[N];
  int m_val[N];

  task automatic chk(string tag, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int model_read(int a);
    int r = 0;
    if (a == 0) for (int i = 0; i < N; i++) r |= m_pend[i] << i;
    else if (a == 1) for (int i = 0; i < N; i++) r |= m_mode[i] << i;
    else if (a == 2) for (int i = 0; i < N; i++) r |= m_ovr[i] << i;
    else if (a >= 4 && a < 4 + N) r = m_val[a-4];
    return r;
  endfunction

  function automatic string addr_tag(int a);
    if (a == 0) return "R2 pending";
    if (a == 1) return "R5 mode";
    if (a == 2) return "R4 overrun";
    if (a >= 4 && a < 4 + N) return "R1 value";
    return "R7 unmapped";
  endfunction

  task automatic cycle(logic [N-1:0] stb, logic [N*DW-1:0] d, logic wr, logic rd, int a, int wd);
    int exp_rd, do_rd, vec_exp, irq_exp;
    int np[N], no[N];
    ev_strobe = stb; ev_data = d; bus_wr = wr; bus_rd = rd;
    bus_addr = AW'(a); bus_wdata = DW'(wd);
    @(posedge clk);
    do_rd  = rd;
    exp_rd = model_read(a);
    for (int i = 0; i < N; i++) begin
      int ack, clr;
      ack = (wr && a == 0) ? ((wd >> i) & 1) : 0;
      clr = (wr && a == 2) ? ((wd >> i) & 1) : 0;
      np[i] = (stb[i] || (m_pend[i] && !ack)) ? 1 : 0;
      no[i] = ((stb[i] && m_pend[i] && !ack) || (m_ovr[i] && !clr)) ? 1 : 0;
      if (stb[i]) m_val[i] = int'(d[i*DW +: DW]);
    end
    for (int i = 0; i < N; i++) begin
      m_pend[i] = np[i];
      m_ovr[i]  = no[i];
      if (wr && a == 1) m_mode[i] = (wd >> i) & 1;
    end
    @(negedge clk);
    irq_exp = 0; vec_exp = 0;
    for (int i = N - 1; i >= 0; i--)
      if (m_pend[i] && m_mode[i]) begin irq_exp = 1; vec_exp = VB + i; end
    chk("R5 irq", int'(irq), irq_exp);
    chk("R6 irq_vec", int'(irq_vec), vec_exp);
    if (do_rd) chk((rd_tag != "") ? rd_tag : addr_tag(a), int'(rd_data), exp_rd);
  endtask

  task automatic idle();
    cycle('0, '0, 1'b0, 1'b0, 0, 0);
  endtask

  task automatic rd_reg(int a);
    cycle('0, '0, 1'b0, 1'b1, a, 0);
  endtask

  task automatic wr_reg(int a, int v);
    cycle('0, '0, 1'b1, 1'b0, a, v);
  endtask

  task automatic fire(int ch, int v);
    logic [N*DW-1:0] d = '0;
    d[ch*DW +: DW] = DW'(v);
    cycle(N'(1 << ch), d, 1'b0, 1'b0, 0, 0);
  endtask

  initial begin : watchdog
    #(20 * 150000);
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin : stim
    logic [N*DW-1:0] d;
    ev_strobe = '0; ev_data = '0; bus_addr = '0; bus_wr = 0; bus_rd = 0; bus_wdata = '0;
    for (int i = 0; i < N; i++) begin m_pend[i] = 0; m_ovr[i] = 0; m_mode[i] = 0; m_val[i] = 0; end
    rst_n = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R8: reset state on every register
    rd_tag = "R8 reset";
    for (int a = 0; a < 8; a++) rd_reg(a);

    // R1: latch and set at the same edge
    rd_tag = "R1 latch";
    fire(2, 8'h5A);
    rd_reg(6);
    rd_reg(0);

    // R2: zero write keeps, one write clears
    rd_tag = "R2 ack";
    wr_reg(0, 4'b1011);
    rd_reg(0);
    wr_reg(0, 4'b0100);
    rd_reg(0);

    // R3: acknowledge and strobe in the same cycle
    rd_tag = "R3 race";
    fire(1, 8'h11);
    d = '0; d[1*DW +: DW] = 8'h22;
    cycle(4'b0010, d, 1'b1, 1'b0, 0, 4'b0010);
    rd_reg(0);
    rd_reg(2);
    rd_reg(5);
    wr_reg(0, 4'b0010);

    // R4: overrun, sticky, clear
    rd_tag = "R4 overrun";
    fire(3, 8'hA1);
    fire(3, 8'hB2);
    rd_reg(2);
    rd_reg(7);
    idle();
    rd_reg(2);
    wr_reg(2, 4'b1000);
    rd_reg(2);
    wr_reg(0, 4'b1000);

    // R5/R6: interrupt mode, priority
    rd_tag = "R5 mode";
    wr_reg(1, 4'b1010);
    rd_reg(1);
    fire(3, 8'h33);
    fire(1, 8'h44);
    fire(0, 8'h55);
    wr_reg(0, 4'b0010);
    wr_reg(0, 4'b1001);

    // R7: reads are side-effect free, value writes ignored
    rd_tag = "R7 quiet";
    fire(2, 8'h66);
    wr_reg(6, 8'hFF);
    for (int k = 0; k < 4; k++) rd_reg(6);
    rd_reg(0);
    rd_reg(15);
    rd_reg(3);

    // mixed random traffic
    rd_tag = "";
    for (int k = 0; k < 4000; k++) begin
      logic [N-1:0] stb;
      int a, wd;
      logic wr, rd;
      stb = '0;
      for (int i = 0; i < N; i++) stb[i] = ($urandom_range(0, 5) == 0);
      for (int i = 0; i < N; i++) d[i*DW +: DW] = DW'($urandom_range(0, 255));
      wr = ($urandom_range(0, 4) == 0);
      rd = ($urandom_range(0, 1) == 0);
      a  = $urandom_range(0, 15);
      wd = $urandom_range(0, 255);
      cycle(stb, d, wr, rd, a, wd);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule